// File: doc/BRIEF.md
# Halfword and Signed Load/Store Address Unit

This block takes one instruction of the halfword / signed-byte / doubleword load-store class and works out where the memory access goes and what happens to the base register. Its inputs are the 32-bit instruction word, the values read for the base and index registers, the address of the instruction, and a flag saying whether the instruction's condition passed. Its outputs are the access address, the value and enable for the base register write, the access kind, the transfer direction, and three flags: the encoding is unallocated, the encoding belongs to another class, or the result is unpredictable. All outputs are registered, so they appear one clock after the inputs are sampled.

The offset is either an 8-bit constant or the index register value. The constant is split across two nibbles of the instruction and is zero-extended. Two instruction bits choose among plain offset, pre-indexed and post-indexed forms. A third bit chooses whether the offset is added or subtracted. The unit holds no architectural state. A surrounding pipeline uses the write enable and value to update its register file, and uses the flags to raise its own exceptions.

Top module: `lsx_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every output is zero.
- R2: When instruction bit 22 is 1, the offset is bits 11:8 as its upper nibble and bits 3:0 as its lower nibble, zero-extended. When bit 22 is 0, the offset is `index_val`.
- R3: Bit 23 set adds the offset to the base, and bit 23 clear subtracts it, modulo 2^DATA_W. `wb_val` always carries this sum or difference.
- R4: With bit 24 set, `addr` is the sum or difference. With bit 24 clear (post-indexed), `addr` is the base itself.
- R5: `wb_en` is 1 only when `cond_pass` is 1, the form writes back (bit 24 clear, or bit 21 set), and neither `unalloc` nor `not_class` is set.
- R6: When bits 19:16 equal 15, the base is `pc_val` + PC_AHEAD (8 by default) instead of `base_val`.
- R7: `kind` encodes 0 = unsigned halfword, 1 = signed byte, 2 = signed halfword, 3 = doubleword, from L = bit 20, S = bit 6, H = bit 5. With L=1: S,H = 01, 10 and 11 give 0, 1 and 2. With L=0: S=1 gives 3, and any other pattern gives 0. `ld` is 1 when L=1, or when L=0, S=1 and H=0 (a doubleword load).
- R8: With DWORD_EN = 0 (the default), L=0 with S=1 raises `unalloc`.
- R9: `not_class` is raised when bits 27:25 are not 000, when bit 7 or bit 4 is 0, or when S=0 and H=0.
- R10: `unpred` is raised for any of: base register 15 in a writeback form; register offset with bits 3:0 equal to 15; register offset in a writeback form with the base and index register numbers equal; register offset with bits 11:8 not zero.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| base_val | input | DATA_W | Base register value |
| index_val | input | DATA_W | Index register value |
| pc_val | input | DATA_W | Address of the instruction |
| cond_pass | input | 1 | Instruction condition passed |
| addr | output | DATA_W | Memory access address |
| wb_val | output | DATA_W | Value for base register update |
| wb_en | output | 1 | Base register update enable |
| kind | output | 2 | Access kind code |
| ld | output | 1 | 1 = load, 0 = store |
| unalloc | output | 1 | Unallocated encoding |
| not_class | output | 1 | Instruction is not of this class |
| unpred | output | 1 | Unpredictable operand choice |

## Verification
On every cycle, the assertions check several properties:
- writeback never happens without a passed condition, and never happens on a flagged encoding;
- the plain-offset form never writes back;
- a post-indexed access goes to the unmodified base, or to the instruction address plus the lead when the base register is 15;
- a set L bit always yields a load;
- an index register of 15 always raises the unpredictable flag.

The remaining behaviour can only be shown by comparing against a reference model over the bench's scenarios. This covers the exact sum and difference with wrap-around, the split constant, the full kind table, the class and unallocated flags, and the reset values.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
   localparam int unsigned INSTR_W = 32;
   localparam int unsigned RIDX_W  = 4;
   localparam int unsigned IMM_W   = 8;
   localparam logic [RIDX_W-1:0] PC_REG = 4'hF;

   typedef enum logic [1:0] {
      KIND_HALF_U = 2'd0,
      KIND_BYTE_S = 2'd1,
      KIND_HALF_S = 2'd2,
      KIND_DOUBLE = 2'd3
   } lsx_kind_e;

   typedef struct packed {
      logic              pre;
      logic              up;
      logic              imm_sel;
      logic              wback;
      logic              lbit;
      logic              sbit;
      logic              hbit;
      logic [RIDX_W-1:0] rn;
      logic [RIDX_W-1:0] rm;
      logic [IMM_W-1:0]  imm8;
      logic              hi_zero;
      logic              frame_ok;
   } lsx_fields_t;
endpackage

// File: rtl/lsx_field_split.sv
module lsx_field_split
   import lsx_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output lsx_fields_t        fld
);
   localparam int unsigned B_PRE = 24;
   localparam int unsigned B_UP  = 23;
   localparam int unsigned B_IMM = 22;
   localparam int unsigned B_WB  = 21;
   localparam int unsigned B_L   = 20;

   logic [7:0] unused_bits;
   assign unused_bits = {instr[31:28], instr[15:12]};

   always_comb begin
      fld.pre      = instr[B_PRE];
      fld.up       = instr[B_UP];
      fld.imm_sel  = instr[B_IMM];
      fld.wback    = instr[B_WB];
      fld.lbit     = instr[B_L];
      fld.sbit     = instr[6];
      fld.hbit     = instr[5];
      fld.rn       = instr[19:16];
      fld.rm       = instr[3:0];
      fld.imm8     = {instr[11:8], instr[3:0]};
      fld.hi_zero  = (instr[11:8] == 4'h0);
      fld.frame_ok = (instr[27:25] == 3'b000) && instr[7] && instr[4];
   end
endmodule

// File: rtl/lsx_class_decode.sv
module lsx_class_decode
   import lsx_pkg::*;
#(
   parameter bit DWORD_EN = 1'b0
) (
   input  lsx_fields_t fld,
   output lsx_kind_e   kind,
   output logic        ld,
   output logic        unalloc,
   output logic        not_class
);
   always_comb begin
      unique case ({fld.sbit, fld.hbit})
         2'b10:   kind = fld.lbit ? KIND_BYTE_S : KIND_DOUBLE;
         2'b11:   kind = fld.lbit ? KIND_HALF_S : KIND_DOUBLE;
         default: kind = KIND_HALF_U;
      endcase
      ld        = fld.lbit | (fld.sbit & ~fld.hbit);
      not_class = ~fld.frame_ok | (~fld.sbit & ~fld.hbit);
   end

   generate
      if (DWORD_EN) begin : g_dword
         assign unalloc = 1'b0;
      end else begin : g_no_dword
         assign unalloc = ~fld.lbit & fld.sbit;
      end
   endgenerate
endmodule

// File: rtl/lsx_addr_unit.sv
module lsx_addr_unit
   import lsx_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PC_AHEAD = 8
) (
   input  lsx_fields_t       fld,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] index_val,
   input  logic [DATA_W-1:0] pc_val,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] sum
);
   localparam int unsigned PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] base_eff;
   logic [DATA_W-1:0] offset;

   always_comb begin
      base_eff = (fld.rn == PC_REG) ? pc_val + DATA_W'(PC_AHEAD) : base_val;
      offset   = fld.imm_sel ? {{PAD_W{1'b0}}, fld.imm8} : index_val;
      sum      = fld.up ? base_eff + offset : base_eff - offset;
      addr     = fld.pre ? sum : base_eff;
   end
endmodule

// File: rtl/lsx_addr_gen.sv
module lsx_addr_gen
   import lsx_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PC_AHEAD = 8,
   parameter bit          DWORD_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] index_val,
   input  logic [DATA_W-1:0] pc_val,
   input  logic              cond_pass,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] wb_val,
   output logic              wb_en,
   output logic [1:0]        kind,
   output logic              ld,
   output logic              unalloc,
   output logic              not_class,
   output logic              unpred
);
   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("lsx_addr_gen: DATA_W must be at least 16");
      end
      if (PC_AHEAD >= (1 << 12)) begin : g_bad_ahead
         $error("lsx_addr_gen: PC_AHEAD out of range");
      end
   endgenerate

   lsx_fields_t       fld;
   lsx_kind_e         kind_c;
   logic              ld_c, ua_c, nc_c, up_c, wbf_c, wb_c;
   logic [DATA_W-1:0] addr_c, sum_c;

   lsx_field_split u_split (
      .instr (instr),
      .fld   (fld)
   );

   lsx_class_decode #(.DWORD_EN(DWORD_EN)) u_class (
      .fld       (fld),
      .kind      (kind_c),
      .ld        (ld_c),
      .unalloc   (ua_c),
      .not_class (nc_c)
   );

   lsx_addr_unit #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_addr (
      .fld       (fld),
      .base_val  (base_val),
      .index_val (index_val),
      .pc_val    (pc_val),
      .addr      (addr_c),
      .sum       (sum_c)
   );

   always_comb begin
      wbf_c = ~fld.pre | fld.wback;
      wb_c  = cond_pass & wbf_c & ~ua_c & ~nc_c;
      up_c  = (wbf_c && fld.rn == PC_REG)
            || (!fld.imm_sel && fld.rm == PC_REG)
            || (!fld.imm_sel && wbf_c && fld.rn == fld.rm)
            || (!fld.imm_sel && !fld.hi_zero);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr      <= '0;
         wb_val    <= '0;
         wb_en     <= 1'b0;
         kind      <= 2'd0;
         ld        <= 1'b0;
         unalloc   <= 1'b0;
         not_class <= 1'b0;
         unpred    <= 1'b0;
      end else begin
         addr      <= addr_c;
         wb_val    <= sum_c;
         wb_en     <= wb_c;
         kind      <= kind_c;
         ld        <= ld_c;
         unalloc   <= ua_c;
         not_class <= nc_c;
         unpred    <= up_c;
      end
   end
endmodule

// File: rtl/lsx_addr_gen_chk.sv
module lsx_addr_gen_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PC_AHEAD = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] base_val,
   input logic [DATA_W-1:0] pc_val,
   input logic              cond_pass,
   input logic [DATA_W-1:0] addr,
   input logic              wb_en,
   input logic              ld,
   input logic              unalloc,
   input logic              not_class,
   input logic              unpred
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_wb_needs_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && wb_en |-> $past(cond_pass));

   p_no_wb_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (unalloc || not_class) |-> !wb_en);

   p_offset_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(instr[24] && !instr[21]) |-> !wb_en);

   p_post_base_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!instr[24] && instr[19:16] != 4'hF) |-> addr == $past(base_val));

   p_pc_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!instr[24] && instr[19:16] == 4'hF)
         |-> addr == $past(pc_val) + DATA_W'(PC_AHEAD));

   p_load_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(instr[20]) |-> ld);

   p_rm15_unpred_r10: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!instr[22] && instr[3:0] == 4'hF) |-> unpred);
endmodule

bind lsx_addr_gen lsx_addr_gen_chk #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr     (instr),
   .base_val  (base_val),
   .pc_val    (pc_val),
   .cond_pass (cond_pass),
   .addr      (addr),
   .wb_en     (wb_en),
   .ld        (ld),
   .unalloc   (unalloc),
   .not_class (not_class),
   .unpred    (unpred)
);

// File: tb/lsx_addr_gen_tb.sv
`timescale 1ns/1ps
module lsx_addr_gen_tb;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   instr = '0;
   logic [DW-1:0] base_val = '0, index_val = '0, pc_val = '0;
   logic          cond_pass = 1'b0;
   logic [DW-1:0] addr, wb_val;
   logic          wb_en, ld, unalloc, not_class, unpred;
   logic [1:0]    kind;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lsx_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .base_val(base_val),
      .index_val(index_val), .pc_val(pc_val), .cond_pass(cond_pass),
      .addr(addr), .wb_val(wb_val), .wb_en(wb_en), .kind(kind), .ld(ld),
      .unalloc(unalloc), .not_class(not_class), .unpred(unpred)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit p, input bit u, input bit i, input bit w,
                                      input bit l, input logic [3:0] rn, input logic [3:0] hi,
                                      input bit s, input bit h, input logic [3:0] lo);
      return {4'hE, 3'b000, p, u, i, w, l, rn, 4'h1, hi, 1'b1, s, h, 1'b1, lo};
   endfunction

   // Reference model built from the requirements
   task automatic check_vec();
      bit p, u, i, w, l, s, h, wbf, nc, ua, up;
      logic [3:0]    rn, rm;
      logic [DW-1:0] b, off, sm, ad;
      logic [1:0]    k;
      p = instr[24]; u = instr[23]; i = instr[22]; w = instr[21]; l = instr[20];
      s = instr[6];  h = instr[5];  rn = instr[19:16]; rm = instr[3:0];
      b   = (rn == 4'hF) ? pc_val + 32'd8 : base_val;            // R6
      off = i ? {24'd0, instr[11:8], instr[3:0]} : index_val;    // R2
      sm  = u ? b + off : b - off;                               // R3
      ad  = p ? sm : b;                                          // R4
      wbf = !p || w;
      nc  = (instr[27:25] != 3'b000) || !instr[7] || !instr[4] || (!s && !h);
      ua  = !l && s;
      if (l) k = (s && h) ? 2'd2 : (s ? 2'd1 : 2'd0);
      else   k = s ? 2'd3 : 2'd0;
      up = (wbf && rn == 4'hF) || (!i && rm == 4'hF) || (!i && wbf && rn == rm)
           || (!i && instr[11:8] != 4'h0);
      chk("R4 R11", "addr", 64'(addr), 64'(ad));
      chk("R3", "wb_val", 64'(wb_val), 64'(sm));
      chk("R5", "wb_en", 64'(wb_en), 64'(cond_pass && wbf && !nc && !ua));
      chk("R7", "kind", 64'(kind), 64'(k));
      chk("R7", "ld", 64'(ld), 64'(l || (s && !h)));
      chk("R8", "unalloc", 64'(unalloc), 64'(ua));
      chk("R9", "not_class", 64'(not_class), 64'(nc));
      chk("R10", "unpred", 64'(unpred), 64'(up));
   endtask

   task automatic apply(input logic [31:0] ins, input logic [DW-1:0] b, input logic [DW-1:0] x,
                        input logic [DW-1:0] pc, input bit cp);
      @(negedge clk);
      instr = ins; base_val = b; index_val = x; pc_val = pc; cond_pass = cp;
      @(posedge clk);
      #1;
      check_vec();
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1: reset clears outputs even with busy inputs
      instr = mk(0, 1, 1, 0, 1, 4'h3, 4'h7, 1, 1, 4'h9);
      base_val = 32'hDEAD_BEEF; pc_val = 32'h100; cond_pass = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "addr", 64'(addr), 64'd0);
      chk("R1", "wb_en", 64'(wb_en), 64'd0);
      chk("R1", "kind|ld|flags", 64'({kind, ld, unalloc, not_class, unpred}), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // R2: split constant 0xA5, offset form
      apply(mk(1, 1, 1, 0, 1, 4'h2, 4'hA, 0, 1, 4'h5), 32'h1000, 32'h0, 32'h0, 1);
      chk("R2", "split imm addr", 64'(addr), 64'h10A5);
      // R3: subtract with wrap
      apply(mk(1, 0, 1, 1, 1, 4'h2, 4'h0, 0, 1, 4'h5), 32'h2, 32'h0, 32'h0, 1);
      chk("R3", "wrap", 64'(wb_val), 64'hFFFF_FFFD);
      // R6: base register 15 in offset form
      apply(mk(1, 1, 1, 0, 1, 4'hF, 4'h0, 1, 1, 4'h4), 32'h5555, 32'h0, 32'h2000, 1);
      chk("R6", "pc base", 64'(addr), 64'h200C);
      // R5: failed condition on post-indexed form, no writeback
      apply(mk(0, 1, 0, 0, 1, 4'h1, 4'h0, 0, 1, 4'h2), 32'h40, 32'h8, 32'h0, 0);
      chk("R5", "cond fail", 64'(wb_en), 64'd0);
      // R8: store with S=1 is unallocated, blocks writeback
      apply(mk(0, 1, 1, 0, 0, 4'h1, 4'h0, 1, 0, 4'h4), 32'h40, 32'h0, 32'h0, 1);
      chk("R8", "unalloc", 64'({unalloc, wb_en}), 64'b10);
      // R9: S=H=0 not this class
      apply(mk(0, 1, 1, 0, 1, 4'h1, 4'h0, 0, 0, 4'h4), 32'h40, 32'h0, 32'h0, 1);
      chk("R9", "not_class", 64'({not_class, wb_en}), 64'b10);
      // R10: same base and index register in writeback form
      apply(mk(1, 1, 0, 1, 1, 4'h6, 4'h0, 1, 1, 4'h6), 32'h40, 32'h4, 32'h0, 1);
      chk("R10", "rn==rm", 64'(unpred), 64'd1);

      // Constrained random
      for (int n = 0; n < 400; n++) begin
         logic [31:0] ins;
         logic [31:0] x;
         ins = $urandom;
         if ($urandom_range(7) != 0) begin
            ins[27:25] = 3'b000; ins[7] = 1'b1; ins[4] = 1'b1;
         end
         if (!ins[22] && $urandom_range(1) == 0) ins[11:8] = 4'h0;
         if ($urandom_range(7) == 0) ins[19:16] = 4'hF;
         x = ($urandom_range(1) == 0) ? 32'($urandom_range(255)) : $urandom;
         apply(ins, $urandom, x, $urandom, 1'($urandom_range(1)));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule